// File: doc/BRIEF.md
# Pipelined XTEA Block Encryptor

This block encrypts 64-bit blocks with the extended TEA cipher using a fully unrolled pipeline. Each input block arrives as two 32-bit halves together with its own 128-bit key, given as four 32-bit words, and an input valid strobe. Every pipeline stage performs one complete cycle of the cipher and is followed by a register. As a result, one new block can enter on every clock. The matching ciphertext leaves with an output valid a fixed number of clocks later.

Within one stage, the first half is updated first, using the running sum as it stood before the stage. The sum is then advanced by the delta constant. The second half is updated last, using the advanced sum and the already-updated first half. Each half update adds `((x << 4) ^ (x >> 5)) + x` XOR `(sum + key[idx])` to the half. Here `x` is the other half, and `idx` is a 2-bit index taken from the sum. The running sum starts at zero for every block, so its value at each stage is a constant. The key word each stage uses therefore follows from the stage position.

Top module: `xtea_pipe_enc`

## Requirements
- R1: After reset is released, `out_valid` is low, and it stays low until the first accepted block has passed through all stages.
- R2: `out_valid` equals `in_valid` delayed by exactly ROUNDS clocks (default 32), for any pattern of valid pulses.
- R3: Each output block equals ROUNDS cipher cycles applied to its input. In every cycle the first half is updated with the old sum, the sum is then increased by 32'h9E3779B9, and the second half is updated with the new sum. The sum starts at zero, all additions wrap modulo 2^32, and the shifts are logical.
- R4: The first-half update takes the key word indexed by sum bits [1:0] of the old sum. The second-half update takes the key word indexed by bits [12:11] of the new sum. Key word 0 is `in_key[0]` (bits 31:0) and key word 3 is `in_key[3]` (bits 127:96).
- R5: Blocks presented on consecutive clocks all come out on consecutive clocks. A burst of n blocks completes ROUNDS + n − 1 clocks after its first block is accepted.
- R6: Each block is encrypted with the key that was presented with it, even when the key changes on every clock.
- R7: Extreme operands give correct results: all-zero inputs, all-ones inputs and key, and values whose sums overflow 32 bits.
- R8: Clocks with `in_valid` low produce no output, and they do not disturb blocks already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid chain |
| in_valid | input | 1 | A block is presented this clock |
| in_v0 | input | 32 | First half of the plaintext |
| in_v1 | input | 32 | Second half of the plaintext |
| in_key | input | 4x32 | Key words, index 0 in the low 32 bits |
| out_valid | output | 1 | Ciphertext on the outputs is valid |
| out_v0 | output | 32 | First half of the ciphertext |
| out_v1 | output | 32 | Second half of the ciphertext |

## Verification
The bench builds the core with its defaults: 32 stages and the standard delta. With these values the output can be compared directly against a plain loop model of the cipher. The valid strobe is swept through long back-to-back bursts and random sparse patterns, and the expected output valid is checked on every clock against the input history shifted by 32. Keys whose four words all differ are used throughout, and the key changes per block. A stage that picks the wrong key word, uses the sum from the wrong side of the delta step, or uses a neighbouring block's key therefore shows up as a data mismatch.

// File: rtl/xtea_pipe_enc.sv
module xtea_pipe_enc #(
  parameter int          ROUNDS = 32,
  parameter logic [31:0] DELTA  = 32'h9E3779B9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      in_v0,
  input  logic [31:0]      in_v1,
  input  logic [3:0][31:0] in_key,
  output logic             out_valid,
  output logic [31:0]      out_v0,
  output logic [31:0]      out_v1
);

  // ROUNDS must be at least 2: the key travels through stages 1..ROUNDS-1.
  logic [31:0]      v0_r  [1:ROUNDS];
  logic [31:0]      v1_r  [1:ROUNDS];
  logic             vld_r [1:ROUNDS];
  logic [3:0][31:0] key_r [1:ROUNDS-1];

  function automatic logic [31:0] mix(input logic [31:0] x);
    return ((x << 4) ^ (x >> 5)) + x;
  endfunction

  for (genvar i = 0; i < ROUNDS; i++) begin : g_stage
    localparam logic [31:0] SUM_PRE  = 32'(i) * DELTA;
    localparam logic [31:0] SUM_POST = SUM_PRE + DELTA;

    logic [31:0]      a0, a1, b0, b1;
    logic [3:0][31:0] kk;
    logic             va;

    if (i == 0) begin : g_head
      assign a0 = in_v0;
      assign a1 = in_v1;
      assign kk = in_key;
      assign va = in_valid;
    end else begin : g_body
      assign a0 = v0_r[i];
      assign a1 = v1_r[i];
      assign kk = key_r[i];
      assign va = vld_r[i];
    end

    assign b0 = a0 + (mix(a1) ^ (SUM_PRE  + kk[SUM_PRE[1:0]]));
    assign b1 = a1 + (mix(b0) ^ (SUM_POST + kk[SUM_POST[12:11]]));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) vld_r[i+1] <= 1'b0;
      else        vld_r[i+1] <= va;

    always_ff @(posedge clk) begin
      v0_r[i+1] <= b0;
      v1_r[i+1] <= b1;
    end

    if (i < ROUNDS - 1) begin : g_key
      always_ff @(posedge clk) key_r[i+1] <= kk;
    end
  end

  assign out_valid = vld_r[ROUNDS];
  assign out_v0    = v0_r[ROUNDS];
  assign out_v1    = v1_r[ROUNDS];

endmodule

// File: rtl/xtea_pipe_enc_chk.sv
module xtea_pipe_enc_chk #(
  parameter int ROUNDS = 32
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic out_valid
);

  localparam int CW = $clog2(ROUNDS + 1) + 1;

  logic [CW-1:0] since_rst, idle_run, busy_run;
  logic [31:0]   accepted, emitted;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      since_rst <= '0;
      idle_run  <= '0;
      busy_run  <= '0;
      accepted  <= '0;
      emitted   <= '0;
    end else begin
      if (since_rst < CW'(ROUNDS)) since_rst <= since_rst + 1'b1;
      idle_run <= in_valid ? '0 : ((idle_run < CW'(ROUNDS)) ? idle_run + 1'b1 : idle_run);
      busy_run <= !in_valid ? '0 : ((busy_run < CW'(ROUNDS)) ? busy_run + 1'b1 : busy_run);
      accepted <= accepted + 32'(in_valid);
      emitted  <= emitted + 32'(out_valid);
    end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < CW'(ROUNDS)) |-> !out_valid);

  a_r8_idle_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_run == CW'(ROUNDS)) |-> !out_valid);

  a_r5_burst_streams: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_run == CW'(ROUNDS)) |-> out_valid);

  a_r2_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (emitted <= accepted) && ((accepted - emitted) <= 32'(ROUNDS)));

  a_r2_valid_known: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(out_valid));

endmodule

bind xtea_pipe_enc xtea_pipe_enc_chk #(.ROUNDS(ROUNDS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .out_valid(out_valid)
);

// File: tb/tb_xtea_pipe_enc.sv
`timescale 1ns/1ps
module tb_xtea_pipe_enc;

  localparam int          ROUNDS = 32;
  localparam logic [31:0] DELTA  = 32'h9E3779B9;
  localparam int          DEPTH  = 4096;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic [31:0]      in_v0, in_v1;
  logic [3:0][31:0] in_key;
  logic             out_valid;
  logic [31:0]      out_v0, out_v1;

  always #2 clk = ~clk;

  xtea_pipe_enc #(.ROUNDS(ROUNDS), .DELTA(DELTA)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_v0(in_v0), .in_v1(in_v1),
    .in_key(in_key), .out_valid(out_valid), .out_v0(out_v0), .out_v1(out_v1)
  );

  int    checks = 0, errors = 0;
  int    cyc = 0, wr = 0, rd = 0;
  logic  inhist [0:DEPTH-1];
  logic [63:0] exp_q [0:DEPTH-1];
  string tag_q [0:DEPTH-1];
  string cur_tag = "R3";

  function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [3:0][31:0] k);
    logic [31:0] s = 32'd0;
    for (int r = 0; r < ROUNDS; r++) begin
      a = a + ((((b << 4) ^ (b >> 5)) + b) ^ (s + k[s[1:0]]));
      s = s + DELTA;
      b = b + ((((a << 4) ^ (a >> 5)) + a) ^ (s + k[s[12:11]]));
    end
    return {a, b};
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Reference bookkeeping at the capture edge.
  always @(posedge clk) if (rst_n) begin
    cyc = cyc + 1;
    inhist[cyc % DEPTH] = in_valid;
    if (in_valid) begin
      exp_q[wr % DEPTH] = model(in_v0, in_v1, in_key);
      tag_q[wr % DEPTH] = cur_tag;
      wr = wr + 1;
    end
  end

  // Output observation away from the edge.
  always @(negedge clk) if (rst_n && cyc > 0) begin
    logic ev;
    ev = (cyc >= ROUNDS) ? inhist[(cyc - ROUNDS + 1) % DEPTH] : 1'b0;
    check(out_valid === ev, (cyc < ROUNDS) ? "R1" : "R2", "out_valid timing",
          64'(out_valid), 64'(ev));
    if (out_valid === 1'b1) begin
      check({out_v0, out_v1} === exp_q[rd % DEPTH], tag_q[rd % DEPTH],
            $sformatf("ciphertext of block %0d", rd), {out_v0, out_v1}, exp_q[rd % DEPTH]);
      rd = rd + 1;
    end
  end

  task automatic send(input logic [31:0] a, input logic [31:0] b,
                      input logic [3:0][31:0] k, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_v0 = a; in_v1 = b; in_key = k; cur_tag = tag;
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      in_valid = 1'b0; in_v0 = $urandom; in_v1 = $urandom;
      in_key = {$urandom, $urandom, $urandom, $urandom};
    end
  endtask

  function automatic logic [3:0][31:0] rkey();
    logic [3:0][31:0] k;
    k = {$urandom, $urandom, $urandom, $urandom};
    return k;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_v0 = '0; in_v1 = '0; in_key = '0;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      check(out_valid === 1'b0, "R1", "out_valid during reset", 64'(out_valid), 64'd0);
    end
    @(negedge clk); rst_n = 1'b1;

    // Corner operands (R7) and distinct key words (R4).
    send('0, '0, '0, "R7");
    send('1, '1, '1, "R7");
    send(32'h41424344, 32'h45464748,
         {32'h0C0D0E0F, 32'h08090A0B, 32'h04050607, 32'h00010203}, "R4");
    send(32'h80000000, 32'hFFFFFFF0,
         {32'hFFFFFFFF, 32'h00000001, 32'h7FFFFFFF, 32'h80000000}, "R7");
    send(32'h01234567, 32'h89ABCDEF,
         {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111}, "R4");
    send(32'h01234567, 32'h89ABCDEF,
         {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111112}, "R4");
    idle(ROUNDS + 2);

    // Back-to-back burst, key changes every clock (R5, R6).
    for (int j = 0; j < 400; j++) send($urandom, $urandom, rkey(), "R6");
    idle(ROUNDS - 1);
    #1 check(rd == wr - 1, "R5", "blocks out one clock before burst end", 64'(rd), 64'(wr - 1));
    idle(1);
    #1 check(rd == wr, "R5", "burst complete at latency + n - 1", 64'(rd), 64'(wr));
    idle(4);

    // Sparse valid patterns (R8) with random data (R3).
    for (int j = 0; j < 600; j++) begin
      if ($urandom_range(0, 2) != 0) send($urandom, $urandom, rkey(), "R8");
      else idle(1 + $urandom_range(0, 2));
    end
    for (int j = 0; j < 200; j++) send($urandom, $urandom, rkey(), "R3");
    idle(ROUNDS + 4);
    check(rd == wr, "R8", "all accepted blocks emitted", 64'(rd), 64'(wr));
    check(out_valid === 1'b0, "R8", "quiet after drain", 64'(out_valid), 64'd0);

    summary();
    $finish;
  end

endmodule